// File: doc/BRIEF.md
# Tunneled Peripheral Configuration Access Controller

This block sits on the host side of a serial peripheral link. Software uses it to read and write the 12-bit configuration space of up to four attached peripherals. The block has two 32-bit registers, selected by a one-bit select input: a control register and a data register.

A write to the control register with its start bit set launches one access. The access uses the kind, target and address fields written by that same write. Reads and writes leave through a valid/ready request channel toward a link engine. The reply comes back on a valid/ready response channel. The outcome is recorded in a three-bit status field that software clears by writing ones to it. A lock bit can only be set, and only reset clears it. Once it is set, configuration writes into the protected low window of the address space never reach the link.

Back-pressure rules: once the block raises `req_valid`, it holds the valid signal and the whole request payload steady until a cycle in which `req_ready` is high. The block raises `rsp_ready` only while it waits for the reply. A reply is taken in a cycle with both `rsp_valid` and `rsp_ready` high.

Top module: `cfgt_ctrl`

## Requirements
- R1: After reset both registers read as zero, `req_valid` is low and `rsp_ready` is low.
- R2: The control register reads back as follows. Bit 31 is busy/start, 30:28 is status, 27 is lock, 20:19 is target, 17:16 is kind and 11:0 is address. Bits 26:21, 18 and 15:12 always read zero.
- R3: Kind 00 is a read. The request carries `req_write`=0 and the programmed target and address. A reply without error stores `rsp_data` in the data register, sets status to 001 and clears bit 31.
- R4: Kind 01 is a write. The request carries `req_write`=1 with `req_wdata` equal to the data register. A reply without error sets status to 001 and leaves the data register unchanged.
- R5: A reply with `rsp_err` high sets status to 010 and leaves the data register unchanged.
- R6: Kinds 10 and 11 raise no request. They complete with status 010 one cycle after the start write.
- R7: Writing 1 to bit 27 sets the lock. Writing 0 to it has no effect. Only reset clears it.
- R8: While the lock is set, a write to an address at or below 0x7FF raises no request and completes with status 100. Writes above 0x7FF and reads at any address still reach the link.
- R9: Writing 1 to a status bit clears that bit alone. A start write while the status is non-zero is ignored.
- R10: While an access is busy, start writes are ignored. Control-field writes and data-register writes are also ignored until the access completes.
- R11: A pending request keeps `req_valid` and its payload stable until `req_ready`. `rsp_ready` is high only while a reply is awaited, and never together with `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read value of the selected register |
| req_valid | output | 1 | Request to the link engine is valid |
| req_ready | input | 1 | Link engine accepts the request |
| req_write | output | 1 | 1 for a configuration write, 0 for a read |
| req_target | output | 2 | Peripheral index |
| req_addr | output | 12 | Configuration address |
| req_wdata | output | 32 | Write data for the peripheral |
| rsp_valid | input | 1 | Reply from the link engine is valid |
| rsp_ready | output | 1 | Block is waiting for a reply |
| rsp_err | input | 1 | Reply reports a link error |
| rsp_data | input | 32 | Read data in the reply |

## Verification
The bench builds the block with its default protected-window top of 0x7FF. This puts the window edge within reach on both sides: 0x7FF, 0x800 and 0x000. The same run also covers lock arming inside a start write. The bench's responder holds `req_ready` low for a cycle on every request, so every request meets back-pressure. Busy-time writes, ignored starts while status is pending, and per-bit status clearing are driven as directed cases after the vector table.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;
  localparam int REG_W    = 32;
  localparam int CADDR_W  = 12;
  localparam int TGT_W    = 2;
  localparam int STAT_W   = 3;

  localparam int BIT_GO   = 31;
  localparam int STAT_LSB = 28;
  localparam int BIT_LOCK = 27;
  localparam int TGT_LSB  = 19;
  localparam int KIND_LSB = 16;

  typedef enum logic [1:0] {
    ACC_RD   = 2'b00,
    ACC_WR   = 2'b01,
    ACC_RSV2 = 2'b10,
    ACC_RSV3 = 2'b11
  } acc_kind_t;

  localparam logic [STAT_W-1:0] ST_OK      = 3'b001;
  localparam logic [STAT_W-1:0] ST_LINKERR = 3'b010;
  localparam logic [STAT_W-1:0] ST_BLOCKED = 3'b100;

  typedef struct packed {
    acc_kind_t          kind;
    logic [TGT_W-1:0]   tgt;
    logic [CADDR_W-1:0] addr;
  } acc_cmd_t;
endpackage

// File: rtl/cfgt_regs.sv
module cfgt_regs
  import cfgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [REG_W-1:0]  wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [STAT_W-1:0] done_code,
  input  logic              rsp_latch,
  input  logic [REG_W-1:0]  rsp_data,
  output acc_cmd_t          cmd,
  output logic              lock,
  output logic [STAT_W-1:0] status,
  output logic [REG_W-1:0]  data,
  output logic              go_accept,
  output logic [REG_W-1:0]  ctrl_word
);
  logic ctrl_wr, data_wr;
  logic unused_rsvd;

  assign ctrl_wr   = wr && !sel;
  assign data_wr   = wr && sel;
  assign go_accept = ctrl_wr && wdata[BIT_GO] && !busy && (status == '0);
  assign unused_rsvd = ^{wdata[26:21], wdata[18], wdata[15:12]};

  // control fields: frozen while an access is in flight (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= '0;
    end else if (ctrl_wr && !busy) begin
      cmd.kind <= acc_kind_t'(wdata[KIND_LSB +: 2]);
      cmd.tgt  <= wdata[TGT_LSB +: TGT_W];
      cmd.addr <= wdata[CADDR_W-1:0];
    end
  end

  // set-only lock (R7)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lock <= 1'b0;
    else if (ctrl_wr && wdata[BIT_LOCK]) lock <= 1'b1;
  end

  // status: completion wins, else per-bit write-one-to-clear (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status <= '0;
    else if (done)    status <= done_code;
    else if (ctrl_wr) status <= status & ~wdata[STAT_LSB +: STAT_W];
  end

  // data register: read reply, or software write while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                data <= '0;
    else if (rsp_latch)        data <= rsp_data;
    else if (data_wr && !busy) data <= wdata;
  end

  always_comb begin
    ctrl_word                          = '0;
    ctrl_word[BIT_GO]                  = busy;
    ctrl_word[STAT_LSB +: STAT_W]      = status;
    ctrl_word[BIT_LOCK]                = lock;
    ctrl_word[TGT_LSB +: TGT_W]        = cmd.tgt;
    ctrl_word[KIND_LSB +: 2]           = cmd.kind;
    ctrl_word[CADDR_W-1:0]             = cmd.addr;
  end
endmodule

// File: rtl/cfgt_guard.sv
module cfgt_guard
  import cfgt_pkg::*;
#(
  parameter logic [CADDR_W-1:0] PROT_TOP = 12'h7FF
) (
  input  acc_kind_t          kind,
  input  logic [CADDR_W-1:0] addr,
  input  logic               lock,
  output logic               reject,
  output logic [STAT_W-1:0]  reject_code
);
  logic in_window;
  assign in_window = (addr <= PROT_TOP);

  always_comb begin
    reject      = 1'b0;
    reject_code = ST_OK;
    if (kind == ACC_RSV2 || kind == ACC_RSV3) begin
      reject      = 1'b1;
      reject_code = ST_LINKERR;
    end else if (kind == ACC_WR && lock && in_window) begin
      reject      = 1'b1;
      reject_code = ST_BLOCKED;
    end
  end
endmodule

// File: rtl/cfgt_seq.sv
module cfgt_seq
  import cfgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_accept,
  input  logic              reject,
  input  logic [STAT_W-1:0] reject_code,
  input  acc_kind_t         kind,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              busy,
  output logic              req_valid,
  output logic              rsp_ready,
  output logic              done,
  output logic [STAT_W-1:0] done_code,
  output logic              rsp_latch
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_t;
  seq_state_t state_q, state_d;

  always_comb begin
    state_d   = state_q;
    req_valid = 1'b0;
    rsp_ready = 1'b0;
    done      = 1'b0;
    done_code = ST_OK;
    rsp_latch = 1'b0;
    unique case (state_q)
      S_IDLE: if (go_accept) state_d = S_ISSUE;
      S_ISSUE: begin
        if (reject) begin
          done      = 1'b1;
          done_code = reject_code;
          state_d   = S_IDLE;
        end else begin
          req_valid = 1'b1;
          if (req_ready) state_d = S_WAIT;
        end
      end
      S_WAIT: begin
        rsp_ready = 1'b1;
        if (rsp_valid) begin
          done      = 1'b1;
          done_code = rsp_err ? ST_LINKERR : ST_OK;
          rsp_latch = !rsp_err && (kind == ACC_RD);
          state_d   = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != S_IDLE);
endmodule

// File: rtl/cfgt_ctrl.sv
module cfgt_ctrl
  import cfgt_pkg::*;
#(
  parameter logic [CADDR_W-1:0] PROT_TOP = 12'h7FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_write,
  output logic [TGT_W-1:0]   req_target,
  output logic [CADDR_W-1:0] req_addr,
  output logic [REG_W-1:0]   req_wdata,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic               rsp_err,
  input  logic [REG_W-1:0]   rsp_data
);
  acc_cmd_t          cmd;
  logic              lock_q;
  logic [STAT_W-1:0] status_q;
  logic [REG_W-1:0]  data_q;
  logic [REG_W-1:0]  ctrl_word;
  logic              go_accept, busy, reject, done, rsp_latch;
  logic [STAT_W-1:0] reject_code, done_code;

  cfgt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .busy(busy), .done(done), .done_code(done_code),
    .rsp_latch(rsp_latch), .rsp_data(rsp_data),
    .cmd(cmd), .lock(lock_q), .status(status_q), .data(data_q),
    .go_accept(go_accept), .ctrl_word(ctrl_word)
  );

  cfgt_guard #(.PROT_TOP(PROT_TOP)) u_guard (
    .kind(cmd.kind), .addr(cmd.addr), .lock(lock_q),
    .reject(reject), .reject_code(reject_code)
  );

  cfgt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go_accept(go_accept),
    .reject(reject), .reject_code(reject_code), .kind(cmd.kind),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .busy(busy), .req_valid(req_valid), .rsp_ready(rsp_ready),
    .done(done), .done_code(done_code), .rsp_latch(rsp_latch)
  );

  assign req_write  = (cmd.kind == ACC_WR);
  assign req_target = cmd.tgt;
  assign req_addr   = cmd.addr;
  assign req_wdata  = data_q;
  assign reg_rdata  = reg_sel ? data_q : ctrl_word;
endmodule

// File: rtl/cfgt_chk.sv
module cfgt_chk
  import cfgt_pkg::*;
#(
  parameter logic [CADDR_W-1:0] PROT_TOP = 12'h7FF
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [TGT_W-1:0]   req_target,
  input logic [CADDR_W-1:0] req_addr,
  input logic [REG_W-1:0]   req_wdata,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               busy,
  input logic               lock,
  input logic [STAT_W-1:0]  status,
  input acc_cmd_t           cmd
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_target)
                                && $stable(req_write) && $stable(req_wdata));

  p_rsp_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> busy && !req_valid);

  p_no_rsv_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cmd.kind[1]);

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> !(lock && req_addr <= PROT_TOP));

  p_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> !busy && status != '0);

  p_idle_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status == '0);
endmodule

bind cfgt_ctrl cfgt_chk #(.PROT_TOP(PROT_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_target(req_target), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .busy(busy), .lock(lock_q), .status(status_q), .cmd(cmd)
);

// File: tb/tb_cfgt_ctrl.sv
`timescale 1ns/1ps
module tb_cfgt_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        req_valid, req_ready = 0, req_write;
  logic [1:0]  req_target;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid = 0, rsp_ready, rsp_err = 0;
  logic [31:0] rsp_data = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfgt_ctrl dut (.*);

  typedef struct packed {
    logic [1:0]  typ;
    logic [1:0]  tgt;
    logic [11:0] addr;
    logic        lk;
    logic [31:0] pre;
    logic        err;
    logic [31:0] rd;
    logic [2:0]  st;
    logic        req;
    logic [31:0] dat;
  } vec_t;

  // kind, target, address, lock-in-start, preloaded data, reply error, reply data,
  // expected status, expected request, expected data register
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 12'h012, 1'b0, 32'h1111_1111, 1'b0, 32'hA5A5_0001, 3'b001, 1'b1, 32'hA5A5_0001},
    '{2'd1, 2'd2, 12'h7FF, 1'b0, 32'h2222_2222, 1'b0, 32'h0,         3'b001, 1'b1, 32'h2222_2222},
    '{2'd0, 2'd3, 12'h800, 1'b0, 32'h3333_3333, 1'b1, 32'hFFFF_0000, 3'b010, 1'b1, 32'h3333_3333},
    '{2'd2, 2'd0, 12'h100, 1'b0, 32'h4444_4444, 1'b0, 32'h0,         3'b010, 1'b0, 32'h4444_4444},
    '{2'd3, 2'd1, 12'h900, 1'b0, 32'h4545_4545, 1'b0, 32'h0,         3'b010, 1'b0, 32'h4545_4545},
    '{2'd1, 2'd0, 12'h7FF, 1'b1, 32'h5555_5555, 1'b0, 32'h0,         3'b100, 1'b0, 32'h5555_5555},
    '{2'd1, 2'd3, 12'h000, 1'b0, 32'h6666_6666, 1'b0, 32'h0,         3'b100, 1'b0, 32'h6666_6666},
    '{2'd1, 2'd2, 12'h800, 1'b0, 32'h7777_7777, 1'b0, 32'h0,         3'b001, 1'b1, 32'h7777_7777},
    '{2'd0, 2'd1, 12'h005, 1'b0, 32'h8888_8888, 1'b0, 32'hDEAD_BEEF, 3'b001, 1'b1, 32'hDEAD_BEEF},
    '{2'd1, 2'd0, 12'hFFF, 1'b0, 32'h9999_9999, 1'b1, 32'h0,         3'b010, 1'b1, 32'h9999_9999}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] val);
    reg_wr = 1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic sel, output logic [31:0] val);
    reg_sel = sel; #1; val = reg_rdata;
  endtask

  function automatic logic [31:0] ctrl_val(input logic go, input logic lk, input logic [1:0] tgt,
                                           input logic [1:0] typ, input logic [11:0] addr);
    return {go, 3'b000, lk, 6'b0, tgt, 1'b0, typ, 4'b0, addr};
  endfunction

  // Serve one request with one cycle of back-pressure, then reply.
  task automatic serve(input logic err, input logic [31:0] data, input string tag);
    logic [11:0] a0;
    a0 = req_addr;
    @(negedge clk);
    chk({tag, " R11 valid held under back-pressure"}, 32'(req_valid), 32'd1);
    chk({tag, " R11 addr stable"}, 32'(req_addr), 32'(a0));
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    chk({tag, " R11 rsp_ready while waiting"}, {31'd0, rsp_ready}, 32'd1);
    chk({tag, " R11 no valid while waiting"}, 32'(req_valid), 32'd0);
    rsp_valid = 1; rsp_err = err; rsp_data = data;
    @(negedge clk);
    rsp_valid = 0; rsp_err = 0; rsp_data = '0;
  endtask

  task automatic wait_req(output bit seen);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      if (req_valid) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit seen;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_reg(0, v); chk("R1 ctrl after reset", v, 32'h0);
    rd_reg(1, v); chk("R1 data after reset", v, 32'h0);
    chk("R1 req_valid after reset", 32'(req_valid), 32'd0);
    chk("R1 rsp_ready after reset", 32'(rsp_ready), 32'd0);

    // R2 reserved bits read zero, field positions
    wr_reg(0, 32'h07FF_FFFF);
    rd_reg(0, v); chk("R2 readback mask", v, 32'h001B_0FFF);
    chk("R2 no request without start", 32'(req_valid), 32'd0);

    // table walk: R3 R4 R5 R6 R8
    for (int k = 0; k < NV; k++) begin
      vec_t e;
      string tg;
      e = VECS[k];
      tg = $sformatf("vec%0d", k);
      wr_reg(1, e.pre);
      wr_reg(0, ctrl_val(1'b1, e.lk, e.tgt, e.typ, e.addr));
      wait_req(seen);
      chk({tg, " R6/R8 request raised"}, 32'(seen), 32'(e.req));
      if (seen) begin
        chk({tg, " R3/R4 req_write"}, 32'(req_write), 32'(e.typ == 2'd1));
        chk({tg, " R3 req_target"}, 32'(req_target), 32'(e.tgt));
        chk({tg, " R3 req_addr"}, 32'(req_addr), 32'(e.addr));
        if (e.typ == 2'd1) chk({tg, " R4 req_wdata"}, req_wdata, e.pre);
        serve(e.err, e.rd, tg);
      end
      rd_reg(0, v);
      chk({tg, " R3 start bit cleared"}, 32'(v[31]), 32'd0);
      chk({tg, " R3/R5/R6/R8 status"}, 32'(v[30:28]), 32'(e.st));
      rd_reg(1, v);
      chk({tg, " R3/R4/R5 data register"}, v, e.dat);
      wr_reg(0, 32'h7000_0000);
      rd_reg(0, v);
      chk({tg, " R9 status cleared"}, 32'(v[30:28]), 32'd0);
    end

    // R7 lock survives a write of zero
    wr_reg(0, 32'h0000_0000);
    rd_reg(0, v); chk("R7 lock sticky", 32'(v[27]), 32'd1);

    // R10 writes during busy
    wr_reg(1, 32'h5A5A_0000);
    wr_reg(0, ctrl_val(1'b1, 1'b0, 2'd2, 2'd0, 12'h0AB));
    wait_req(seen);
    chk("R10 request raised", 32'(seen), 32'd1);
    wr_reg(0, ctrl_val(1'b1, 1'b0, 2'd1, 2'd1, 12'h123));
    wr_reg(1, 32'h0BAD_0BAD);
    chk("R10 addr unchanged while busy", 32'(req_addr), 32'h0AB);
    chk("R10 kind unchanged while busy", 32'(req_write), 32'd0);
    chk("R10 data unchanged while busy", req_wdata, 32'h5A5A_0000);
    serve(1'b0, 32'h7777_0000, "busy");
    rd_reg(0, v); chk("R10 single completion status", 32'(v[30:28]), 32'd1);

    // R9 start ignored while status pending, per-bit clear
    wr_reg(0, ctrl_val(1'b1, 1'b0, 2'd0, 2'd0, 12'h010) | 32'h0);
    wait_req(seen);
    chk("R9 start ignored with status pending", 32'(seen), 32'd0);
    rd_reg(0, v); chk("R9 status kept", 32'(v[30:28]), 32'd1);
    wr_reg(0, 32'h2000_0000);
    rd_reg(0, v); chk("R9 clearing other bit keeps status", 32'(v[30:28]), 32'd1);
    wr_reg(0, 32'h1000_0000);
    rd_reg(0, v); chk("R9 clearing own bit", 32'(v[30:28]), 32'd0);

    // R1/R7 reset clears lock
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_reg(0, v); chk("R7 reset clears lock", v, 32'h0);
    rd_reg(1, v); chk("R1 data cleared by reset", v, 32'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule